// File: doc/BRIEF.md
# I2C EEPROM Page-Write Target

This block is the write side of a small serial EEPROM that sits on an I2C bus. It watches the sampled SCL and SDA lines and detects START and STOP. It checks the first byte of each transfer against a fixed 7-bit device address and a write direction bit. The next byte is taken as the byte address. Every byte after that goes into a page buffer. The target acknowledges each accepted byte by pulling SDA low during the ninth clock.

The buffered bytes reach the internal array only when the master sends STOP. If the transfer instead ends with a repeated START, the buffer is dropped. Inside a transfer, the in-page pointer advances through its low four bits only, so bytes beyond the page end wrap to the page start and overwrite earlier bytes.

A write-control input protects the array. If it is high at any point from START through the end of the address byte, every data byte gets NoAck and nothing is stored. A combinational read port lets a test environment inspect the array.

Top module: `i2c_page_eeprom`

## Requirements
- R1: The select byte (7 address bits, MSB first, then the direction bit in the last position) is acknowledged only when its upper 7 bits equal DEV_ADDR and the direction bit is 0.
- R2: After a rejected select byte the block never drives SDA and changes no array location until the next START.
- R3: After an accepted select byte the byte-address byte is always acknowledged. Each data byte is acknowledged when the transfer is not protected.
- R4: On STOP, data byte k of the transfer lands at address {page, (low + k) mod 16}. Here page is bits 7..4 of the byte address and low is bits 3..0. Other pages are untouched.
- R5: When more than 16 bytes are sent, the pointer wraps inside the same page. The later byte replaces the earlier one at a wrapped location.
- R6: If write control is high at any time from START to the end of the address byte, all data bytes get NoAck and the array is not modified.
- R7: Bytes buffered before a repeated START, without an intervening STOP, are never written to the array.
- R8: sda_oe changes only while the sampled SCL is low. It is released at the end of every acknowledge clock.
- R9: After reset, sda_oe is 0 and every array location reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, SDA is pulled low (open drain) |
| wc_i | input | 1 | Write control; high protects the array |
| rd_addr | input | ADDR_W | Inspection read address |
| rd_data | output | 8 | Array byte at rd_addr |

## Verification
The checker module watches several properties on every clock:
- SDA is driven only while SCL is low.
- SDA stays silent after a rejected select byte.
- A protected transfer never acknowledges a data byte and never commits.
- During the data phase the page stays fixed, and the pointer only moves by +1 modulo 16.

Three behaviours can be shown only by the bench scenarios, which compare the whole array against a behavioural model after each transfer:
- the exact byte placement after STOP;
- overwrite by roll-over;
- the discarding of a buffer cut off by a repeated START.

// File: rtl/i2cpw_pkg.sv
package i2cpw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_DEV_ACK,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_SKIP
   } phase_t;
endpackage

// File: rtl/i2cpw_bus_cond.sv
module i2cpw_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int CHAIN = SYNC_STAGES + 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [CHAIN-1:0] scl_sr, sda_sr;

   for (genvar i = 0; i < CHAIN; i++) begin : g_chain
      if (i == 0) begin : g_head
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_sr[0] <= 1'b1;
               sda_sr[0] <= 1'b1;
            end else begin
               scl_sr[0] <= scl_i;
               sda_sr[0] <= sda_i;
            end
      end else begin : g_tail
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) begin
               scl_sr[i] <= 1'b1;
               sda_sr[i] <= 1'b1;
            end else begin
               scl_sr[i] <= scl_sr[i-1];
               sda_sr[i] <= sda_sr[i-1];
            end
      end
   end

   logic scl_prev, sda_prev;
   assign scl_lvl   = scl_sr[CHAIN-2];
   assign sda_lvl   = sda_sr[CHAIN-2];
   assign scl_prev  = scl_sr[CHAIN-1];
   assign sda_prev  = sda_sr[CHAIN-1];
   assign scl_rise  = scl_lvl & ~scl_prev;
   assign scl_fall  = ~scl_lvl & scl_prev;
   assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
   assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/i2cpw_ctrl.sv
module i2cpw_ctrl
   import i2cpw_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR = 7'h50,
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     scl_lvl,
   input  logic                     sda_lvl,
   input  logic                     scl_rise,
   input  logic                     scl_fall,
   input  logic                     start_det,
   input  logic                     stop_det,
   input  logic                     wc_i,
   output logic                     sda_oe,
   output phase_t                   state,
   output logic                     wp,
   output logic [ADDR_W-PAGE_W-1:0] page,
   output logic [PAGE_W-1:0]        ptr,
   output logic                     wr_en,
   output logic [PAGE_W-1:0]        wr_lane,
   output logic [7:0]               wr_byte,
   output logic                     clr_buf,
   output logic                     commit
);
   logic [7:0] shreg;
   logic [3:0] bitcnt;
   logic       byte_phase, guard_phase, byte_done, sel_ok;

   assign byte_phase  = (state == ST_DEV) || (state == ST_ADDR) || (state == ST_DATA);
   assign guard_phase = (state == ST_DEV) || (state == ST_DEV_ACK) || (state == ST_ADDR);
   assign byte_done   = (bitcnt == 4'd8);
   assign sel_ok      = (shreg[7:1] == DEV_ADDR) && !shreg[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         shreg   <= '0;
         bitcnt  <= '0;
         wp      <= 1'b0;
         page    <= '0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         wr_en   <= 1'b0;
         wr_lane <= '0;
         wr_byte <= '0;
         clr_buf <= 1'b0;
         commit  <= 1'b0;
      end else begin
         wr_en   <= 1'b0;
         clr_buf <= 1'b0;
         commit  <= 1'b0;
         if (start_det) begin
            state   <= ST_DEV;
            bitcnt  <= '0;
            wp      <= wc_i;
            sda_oe  <= 1'b0;
            clr_buf <= 1'b1;
         end else if (stop_det) begin
            if ((state == ST_DATA || state == ST_DATA_ACK) && !wp)
               commit <= 1'b1;
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            if (guard_phase && wc_i)
               wp <= 1'b1;
            if (scl_rise && byte_phase) begin
               shreg  <= {shreg[6:0], sda_lvl};
               bitcnt <= bitcnt + 4'd1;
            end
            if (scl_fall && !scl_lvl) begin
               unique case (state)
                  ST_DEV: if (byte_done) begin
                     bitcnt <= '0;
                     if (sel_ok) begin
                        state  <= ST_DEV_ACK;
                        sda_oe <= 1'b1;
                     end else begin
                        state <= ST_SKIP;
                     end
                  end
                  ST_ADDR: if (byte_done) begin
                     bitcnt <= '0;
                     page   <= shreg[ADDR_W-1:PAGE_W];
                     ptr    <= shreg[PAGE_W-1:0];
                     state  <= ST_ADDR_ACK;
                     sda_oe <= 1'b1;
                  end
                  ST_DATA: if (byte_done) begin
                     bitcnt <= '0;
                     state  <= ST_DATA_ACK;
                     if (!wp) begin
                        sda_oe  <= 1'b1;
                        wr_en   <= 1'b1;
                        wr_lane <= ptr;
                        wr_byte <= shreg;
                        ptr     <= ptr + 1'b1;
                     end
                  end
                  ST_DEV_ACK: begin
                     sda_oe <= 1'b0;
                     state  <= ST_ADDR;
                  end
                  ST_ADDR_ACK: begin
                     sda_oe <= 1'b0;
                     state  <= ST_DATA;
                  end
                  ST_DATA_ACK: begin
                     sda_oe <= 1'b0;
                     state  <= ST_DATA;
                  end
                  default: ;
               endcase
            end
         end
      end
   end
endmodule

// File: rtl/i2cpw_store.sv
module i2cpw_store #(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [PAGE_W-1:0]        wr_lane,
   input  logic [7:0]               wr_byte,
   input  logic                     clr_buf,
   input  logic                     commit,
   input  logic [ADDR_W-PAGE_W-1:0] page,
   input  logic [ADDR_W-1:0]        rd_addr,
   output logic [7:0]               rd_data
);
   localparam int LANES = 1 << PAGE_W;
   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0]       pbuf  [LANES];
   logic [LANES-1:0] valid;
   logic [7:0]       mem   [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid <= '0;
         for (int l = 0; l < LANES; l++) pbuf[l] <= '0;
      end else if (clr_buf || commit) begin
         valid <= '0;
      end else if (wr_en) begin
         valid[wr_lane] <= 1'b1;
         pbuf[wr_lane]  <= wr_byte;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
      end else if (commit) begin
         for (int l = 0; l < LANES; l++)
            if (valid[l]) mem[{page, PAGE_W'(l)}] <= pbuf[l];
      end
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_page_eeprom.sv
module i2c_page_eeprom
   import i2cpw_pkg::*;
#(
   parameter logic [6:0] DEV_ADDR    = 7'h50,
   parameter int         ADDR_W      = 8,
   parameter int         PAGE_W      = 4,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic              wc_i,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [7:0]        rd_data
);
   localparam int PG_BITS = ADDR_W - PAGE_W;

   if (ADDR_W > 8 || PAGE_W < 1 || PAGE_W >= ADDR_W) begin : g_bad_geom
      $error("need 1 <= PAGE_W < ADDR_W <= 8");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   phase_t               state;
   logic                 wp, wr_en, clr_buf, commit;
   logic [PG_BITS-1:0]   page;
   logic [PAGE_W-1:0]    ptr, wr_lane;
   logic [7:0]           wr_byte;

   i2cpw_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
   );

   i2cpw_ctrl #(.DEV_ADDR(DEV_ADDR), .ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
      .stop_det(stop_det), .wc_i(wc_i), .sda_oe(sda_oe), .state(state),
      .wp(wp), .page(page), .ptr(ptr), .wr_en(wr_en), .wr_lane(wr_lane),
      .wr_byte(wr_byte), .clr_buf(clr_buf), .commit(commit)
   );

   i2cpw_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_lane(wr_lane),
      .wr_byte(wr_byte), .clr_buf(clr_buf), .commit(commit), .page(page),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );
endmodule

// File: rtl/i2cpw_checker.sv
module i2cpw_checker
   import i2cpw_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int PAGE_W = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     scl_lvl,
   input logic                     sda_oe,
   input phase_t                   state,
   input logic                     wp,
   input logic [ADDR_W-PAGE_W-1:0] page,
   input logic [PAGE_W-1:0]        ptr,
   input logic                     commit
);
   logic in_data;
   assign in_data = (state == ST_DATA) || (state == ST_DATA_ACK);

   AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl); // R8
   AST_SKIP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe); // R2
   AST_WP_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA_ACK && wp) |-> !sda_oe); // R6
   AST_WP_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> !wp); // R6
   AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && $past(in_data)) |-> $stable(page)); // R4
   AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (in_data && $past(in_data) && !$stable(ptr)) |-> (ptr == PAGE_W'($past(ptr) + 1'b1))); // R5
endmodule

bind i2c_page_eeprom i2cpw_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_oe(sda_oe),
   .state(state), .wp(wp), .page(page), .ptr(ptr), .commit(commit)
);

// File: tb/i2c_page_eeprom_tb.sv
`timescale 1ns/1ps
module i2c_page_eeprom_tb;
   localparam logic [6:0] DEV = 7'h50;
   localparam int Q = 5;

   logic clk = 1'b0, rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1, wc = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic sda_oe, sda_line;
   int errs = 0, checks = 0, hold_errs = 0;
   logic [7:0] ref_mem [256];
   logic prev_scl = 1'b1, prev_oe = 1'b0;

   always #5 clk = ~clk;
   assign sda_line = sda_m & ~sda_oe;

   i2c_page_eeprom #(.DEV_ADDR(DEV)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .wc_i(wc), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   // R8: compared on every clock, the drive must not move while SCL is high
   always @(negedge clk) begin
      if (rst_n && scl_m && prev_scl && sda_oe != prev_oe) hold_errs++;
      prev_scl = scl_m;
      prev_oe  = sda_oe;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b0; wait_clk(Q); scl_m = 1'b0; wait_clk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_clk(Q); scl_m = 1'b1; wait_clk(Q);
      sda_m = 1'b1; wait_clk(2 * Q);
   endtask

   task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
      bit got;
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wait_clk(Q); scl_m = 1'b1; wait_clk(2 * Q); scl_m = 1'b0; wait_clk(Q);
      end
      sda_m = 1'b1; wait_clk(Q); scl_m = 1'b1; wait_clk(Q);
      got = (sda_line == 1'b0);
      chk(got == exp_ack, req, int'(got), int'(exp_ack));
      wait_clk(Q); scl_m = 1'b0; wait_clk(Q);
      chk(sda_oe == 1'b0, "R8 release after ack clock", int'(sda_oe), 0);
   endtask

   task automatic cmp_mem(input string req);
      int bad = 0;
      for (int a = 0; a < 256; a++) begin
         rd_addr = 8'(a); #1;
         if (rd_data !== ref_mem[a]) begin
            if (bad == 0) $display("FAIL %s addr=%0h actual=%0h expected=%0h", req, a, rd_data, ref_mem[a]);
            bad++;
         end
      end
      checks++;
      if (bad != 0) errs++;
   endtask

   task automatic txn(input logic [6:0] dev, input bit rw, input logic [7:0] addr,
                      input int n, input logic [7:0] base, input bit prot,
                      input bit finish, input string req);
      bit sel_ok = (dev == DEV) && !rw;
      logic [7:0] d;
      wc = prot;
      bus_start();
      send_byte({dev, rw}, sel_ok, {"R1 select ack ", req});
      send_byte(addr, sel_ok, sel_ok ? {"R3 address ack ", req} : {"R2 silent ", req});
      wc = 1'b0;
      for (int k = 0; k < n; k++) begin
         d = base + 8'(k);
         send_byte(d, sel_ok && !prot,
                   !sel_ok ? {"R2 silent ", req} : prot ? {"R6 nack ", req} : {"R3 data ack ", req});
      end
      if (finish) begin
         bus_stop();
         if (sel_ok && !prot)
            for (int k = 0; k < n; k++)
               ref_mem[{addr[7:4], 4'((addr[3:0] + k) % 16)}] = base + 8'(k);
         wait_clk(10);
         cmp_mem(req);
      end
   endtask

   initial begin
      for (int a = 0; a < 256; a++) ref_mem[a] = '0;
      wait_clk(4); rst_n = 1'b1; wait_clk(4);
      chk(sda_oe == 1'b0, "R9 sda_oe after reset", int'(sda_oe), 0);
      cmp_mem("R9 array after reset");

      txn(DEV, 1'b0, 8'h23, 1, 8'hA5, 1'b0, 1'b1, "R4 single byte");
      txn(DEV, 1'b0, 8'h50, 4, 8'h10, 1'b0, 1'b1, "R4 four bytes");
      txn(DEV, 1'b0, 8'h3C, 6, 8'h60, 1'b0, 1'b1, "R5 wrap at page end");
      txn(DEV, 1'b0, 8'h7A, 20, 8'hC0, 1'b0, 1'b1, "R5 overwrite by roll-over");
      txn(DEV, 1'b0, 8'h50, 3, 8'hEE, 1'b1, 1'b1, "R6 protected page write");
      txn(7'h51, 1'b0, 8'h90, 2, 8'h77, 1'b0, 1'b1, "R2 wrong device");
      txn(DEV, 1'b1, 8'h91, 1, 8'h33, 1'b0, 1'b1, "R1 read direction rejected");
      txn(DEV, 1'b0, 8'hA0, 3, 8'h44, 1'b0, 1'b0, "R7 cut by repeated start");
      txn(DEV, 1'b0, 8'hB4, 2, 8'h99, 1'b0, 1'b1, "R7 after repeated start");
      txn(DEV, 1'b0, 8'h2F, 2, 8'h5A, 1'b0, 1'b1, "R4 after protection cleared");

      chk(hold_errs == 0, "R8 drive stable while SCL high", hold_errs, 0);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #3000000;
      errs++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule